// File: doc/BRIEF.md
# Predicated Vector Compare-Branch Evaluator

This block decides whether a vectorised conditional branch is taken. A request gives a vector length, a predicate mask, an invert flag, a compare operation and two operand descriptors. Each descriptor is a register base number and a flag that marks it as a vector, meaning a run of consecutive registers, or as a scalar, meaning one register reused for every element. The block walks the elements one per clock. It drives a read address for each operand and takes the returned data in the same cycle. It compares each active pair and collects a per-element pass mask.

When both operands are scalar, the block does a single plain compare and branches on that result. In vector mode the branch is taken only when the pass mask equals the effective predicate exactly, so every active compare has to succeed. The finished mask can also be sent out as a write to a predicate register. When no target is configured, the mask stays in an internal accumulator and nothing is written. The register file, the configuration tables and the program-counter update all live outside the block.

Top module: `vcmp_branch_eval`

## Requirements
- R1: After reset, done, taken, predWrEn and busy are low and resultMask is zero.
- R2: When vecA and vecB are both 0 (scalar mode), the predicate and invert inputs are ignored. done pulses on the first clock edge after the start edge, taken equals the single compare result, resultMask is zero and no predicate write occurs.
- R3: The cmpOp encodings are 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than, 4 signed greater-or-equal and 5 unsigned greater-or-equal. Codes 6 and 7 never pass.
- R4: While busy on element i, a vector operand's read address is its base plus i (modulo the register count), and a scalar operand's read address is its base.
- R5: resultMask bit i is 1 only when i is below the vector length, the effective predicate bit i is 1 and the compare of element i passes. All other bits are 0, and nothing carries over from an earlier request.
- R6: The effective predicate is predMask, or its bitwise complement when predInvert is 1, restricted to bit positions below the vector length. In vector mode, taken is 1 exactly when resultMask equals the effective predicate, so a zero vector length is taken.
- R7: In vector mode, done is a single-cycle pulse that appears max(VL,1) clock edges after the start edge. A vecLen above MAXVL is treated as MAXVL.
- R8: In vector mode with hasTarget set, predWrEn pulses together with done, predWrIdx equals targetReg and predWrData equals resultMask. Otherwise predWrEn stays low.
- R9: busy rises on the edge that accepts start. A start that arrives while busy is ignored and does not change the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| vecLen | input | VLW | Vector length (clamped to MAXVL) |
| predMask | input | MAXVL | Predicate mask taken from the second source |
| predInvert | input | 1 | Complement the predicate before use |
| cmpOp | input | 3 | Compare operation code |
| vecA | input | 1 | Operand A is a vector |
| vecB | input | 1 | Operand B is a vector |
| baseA | input | REGW | Operand A register base |
| baseB | input | REGW | Operand B register base |
| hasTarget | input | 1 | A predicate target register is configured |
| targetReg | input | REGW | Predicate target register number |
| rdAddrA | output | REGW | Operand A read address |
| rdAddrB | output | REGW | Operand B read address |
| rdDataA | input | XLEN | Operand A read data (same cycle) |
| rdDataB | input | XLEN | Operand B read data (same cycle) |
| busy | output | 1 | Element walk in progress |
| done | output | 1 | Result strobe |
| taken | output | 1 | Branch decision, valid with done |
| resultMask | output | MAXVL | Per-element pass mask, valid with done |
| predWrEn | output | 1 | Predicate register write strobe |
| predWrIdx | output | REGW | Predicate register write index |
| predWrData | output | MAXVL | Predicate register write data |

## Verification
Counting the edge that accepts start as edge 0, element k's read addresses are valid in the cycle after edge k. done, taken, resultMask and any predicate write appear together after edge max(VL,1), or after edge 1 in scalar mode. The bench drives inputs and samples outputs on falling edges. It checks addresses after every edge of the walk, checks that done is still low one edge before it is due, and checks the results on the due cycle and the cycle after it, when done must have fallen again. A start pushed in mid-walk with different parameters must leave the expected result unchanged.

// File: rtl/vcbe_pkg.sv
package vcbe_pkg;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd2,
    CMP_LTU = 3'd3,
    CMP_GE  = 3'd4,
    CMP_GEU = 3'd5
  } cmpOp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walkState_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStrobe_t;

endpackage

// File: rtl/vcbe_control.sv
module vcbe_control
  import vcbe_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [IDXW-1:0] lastIdx,
  output ctrlStrobe_t     strobe,
  output logic [IDXW-1:0] elemIdx,
  output logic            busy
);

  walkState_e state;

  always_comb begin
    strobe.load   = start && (state == ST_IDLE);
    strobe.step   = (state == ST_WALK);
    strobe.finish = (state == ST_WALK) && (elemIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
    end else if (strobe.load) begin
      state   <= ST_WALK;
      elemIdx <= '0;
    end else if (strobe.finish) begin
      state   <= ST_IDLE;
      elemIdx <= '0;
    end else if (strobe.step) begin
      elemIdx <= elemIdx + 1'b1;
    end
  end

  assign busy = (state == ST_WALK);

endmodule

// File: rtl/vcbe_datapath.sv
module vcbe_datapath
  import vcbe_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MAXVL = 8,
  parameter int REGW  = 5,
  parameter int VLW   = 4,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [IDXW-1:0]  elemIdx,
  input  logic [VLW-1:0]   vecLen,
  input  logic [MAXVL-1:0] predMask,
  input  logic             predInvert,
  input  logic [2:0]       cmpOp,
  input  logic             vecA,
  input  logic             vecB,
  input  logic [REGW-1:0]  baseA,
  input  logic [REGW-1:0]  baseB,
  input  logic             hasTarget,
  input  logic [REGW-1:0]  targetReg,
  input  logic [XLEN-1:0]  rdDataA,
  input  logic [XLEN-1:0]  rdDataB,
  output logic [IDXW-1:0]  lastIdx,
  output logic [REGW-1:0]  rdAddrA,
  output logic [REGW-1:0]  rdAddrB,
  output logic             done,
  output logic             taken,
  output logic [MAXVL-1:0] resultMask,
  output logic             predWrEn,
  output logic [REGW-1:0]  predWrIdx,
  output logic [MAXVL-1:0] predWrData
);

  localparam logic [VLW-1:0] LEN_CAP = VLW'(MAXVL);

  function automatic logic [MAXVL-1:0] lenMask(input logic [VLW-1:0] len);
    logic [MAXVL-1:0] m;
    for (int i = 0; i < MAXVL; i++) m[i] = (VLW'(i) < len);
    return m;
  endfunction

  logic             cfgVecA, cfgVecB, cfgHasTgt;
  logic [REGW-1:0]  cfgBaseA, cfgBaseB, cfgTgt;
  logic [2:0]       cfgOp;
  logic [VLW-1:0]   cfgLen;
  logic [MAXVL-1:0] cfgPred;
  logic [MAXVL-1:0] accMask, accNext;
  logic             scalarMode, pass, hitBit;
  logic [VLW-1:0]   lenIn;

  assign lenIn      = (vecLen > LEN_CAP) ? LEN_CAP : vecLen;
  assign scalarMode = !cfgVecA && !cfgVecB;
  assign lastIdx    = (scalarMode || cfgLen == '0) ? '0 : IDXW'(cfgLen - 1'b1);
  assign rdAddrA    = cfgVecA ? cfgBaseA + REGW'(elemIdx) : cfgBaseA;
  assign rdAddrB    = cfgVecB ? cfgBaseB + REGW'(elemIdx) : cfgBaseB;

  always_comb begin
    case (cfgOp)
      CMP_EQ:  pass = (rdDataA == rdDataB);
      CMP_NE:  pass = (rdDataA != rdDataB);
      CMP_LT:  pass = ($signed(rdDataA) <  $signed(rdDataB));
      CMP_LTU: pass = (rdDataA <  rdDataB);
      CMP_GE:  pass = ($signed(rdDataA) >= $signed(rdDataB));
      CMP_GEU: pass = (rdDataA >= rdDataB);
      default: pass = 1'b0;
    endcase
  end

  assign hitBit  = (VLW'(elemIdx) < cfgLen) && cfgPred[elemIdx] && pass;
  assign accNext = accMask | (hitBit ? (MAXVL'(1) << elemIdx) : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgVecA    <= 1'b0;
      cfgVecB    <= 1'b0;
      cfgHasTgt  <= 1'b0;
      cfgBaseA   <= '0;
      cfgBaseB   <= '0;
      cfgTgt     <= '0;
      cfgOp      <= '0;
      cfgLen     <= '0;
      cfgPred    <= '0;
      accMask    <= '0;
      done       <= 1'b0;
      taken      <= 1'b0;
      resultMask <= '0;
      predWrEn   <= 1'b0;
      predWrIdx  <= '0;
      predWrData <= '0;
    end else begin
      done     <= 1'b0;
      predWrEn <= 1'b0;
      if (strobe.load) begin
        cfgVecA   <= vecA;
        cfgVecB   <= vecB;
        cfgHasTgt <= hasTarget;
        cfgBaseA  <= baseA;
        cfgBaseB  <= baseB;
        cfgTgt    <= targetReg;
        cfgOp     <= cmpOp;
        cfgLen    <= lenIn;
        cfgPred   <= (predMask ^ {MAXVL{predInvert}}) & lenMask(lenIn);
        accMask   <= '0;
      end
      if (strobe.step) accMask <= accNext;
      if (strobe.finish) begin
        done       <= 1'b1;
        taken      <= scalarMode ? pass : (accNext == cfgPred);
        resultMask <= scalarMode ? '0 : accNext;
        predWrEn   <= !scalarMode && cfgHasTgt;
        predWrIdx  <= cfgTgt;
        predWrData <= scalarMode ? '0 : accNext;
      end
    end
  end

endmodule

// File: rtl/vcmp_branch_eval.sv
module vcmp_branch_eval
  import vcbe_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MAXVL = 8,
  parameter int REGW  = 5,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VLW-1:0]   vecLen,
  input  logic [MAXVL-1:0] predMask,
  input  logic             predInvert,
  input  logic [2:0]       cmpOp,
  input  logic             vecA,
  input  logic             vecB,
  input  logic [REGW-1:0]  baseA,
  input  logic [REGW-1:0]  baseB,
  input  logic             hasTarget,
  input  logic [REGW-1:0]  targetReg,
  output logic [REGW-1:0]  rdAddrA,
  output logic [REGW-1:0]  rdAddrB,
  input  logic [XLEN-1:0]  rdDataA,
  input  logic [XLEN-1:0]  rdDataB,
  output logic             busy,
  output logic             done,
  output logic             taken,
  output logic [MAXVL-1:0] resultMask,
  output logic             predWrEn,
  output logic [REGW-1:0]  predWrIdx,
  output logic [MAXVL-1:0] predWrData
);

  ctrlStrobe_t     strobe;
  logic [IDXW-1:0] elemIdx;
  logic [IDXW-1:0] lastIdx;

  vcbe_control #(.IDXW(IDXW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastIdx (lastIdx),
    .strobe  (strobe),
    .elemIdx (elemIdx),
    .busy    (busy)
  );

  vcbe_datapath #(
    .XLEN(XLEN), .MAXVL(MAXVL), .REGW(REGW), .VLW(VLW), .IDXW(IDXW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .elemIdx    (elemIdx),
    .vecLen     (vecLen),
    .predMask   (predMask),
    .predInvert (predInvert),
    .cmpOp      (cmpOp),
    .vecA       (vecA),
    .vecB       (vecB),
    .baseA      (baseA),
    .baseB      (baseB),
    .hasTarget  (hasTarget),
    .targetReg  (targetReg),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .lastIdx    (lastIdx),
    .rdAddrA    (rdAddrA),
    .rdAddrB    (rdAddrB),
    .done       (done),
    .taken      (taken),
    .resultMask (resultMask),
    .predWrEn   (predWrEn),
    .predWrIdx  (predWrIdx),
    .predWrData (predWrData)
  );

endmodule

// File: rtl/vcmp_branch_eval_checker.sv
module vcmp_branch_eval_checker #(
  parameter int MAXVL = 8,
  parameter int REGW  = 5,
  parameter int VLW   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [VLW-1:0]   vecLen,
  input logic [MAXVL-1:0] predMask,
  input logic             predInvert,
  input logic             vecA,
  input logic             vecB,
  input logic [REGW-1:0]  baseA,
  input logic [REGW-1:0]  rdAddrA,
  input logic             busy,
  input logic             done,
  input logic             taken,
  input logic [MAXVL-1:0] resultMask,
  input logic             predWrEn,
  input logic [MAXVL-1:0] predWrData
);

  function automatic logic [MAXVL-1:0] ckMaskOf(input logic [VLW-1:0] len);
    logic [MAXVL-1:0] m;
    for (int i = 0; i < MAXVL; i++) m[i] = (VLW'(i) < len);
    return m;
  endfunction

  logic [VLW-1:0]   ckLen;
  logic [MAXVL-1:0] ckEff;
  logic             ckScalar, ckVecA;
  logic [REGW-1:0]  ckBaseA;
  logic [VLW-1:0]   lenNow;

  assign lenNow = (vecLen > VLW'(MAXVL)) ? VLW'(MAXVL) : vecLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckLen <= '0; ckEff <= '0; ckScalar <= 1'b0; ckVecA <= 1'b0; ckBaseA <= '0;
    end else if (start && !busy) begin
      ckLen    <= lenNow;
      ckEff    <= (predMask ^ {MAXVL{predInvert}}) & ckMaskOf(lenNow);
      ckScalar <= !vecA && !vecB;
      ckVecA   <= vecA;
      ckBaseA  <= baseA;
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_write_with_done: assert property (@(posedge clk) disable iff (!rstN)
    predWrEn |-> done);

  a_r8_write_data: assert property (@(posedge clk) disable iff (!rstN)
    predWrEn |-> (predWrData == resultMask));

  a_r5_high_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((resultMask & ~ckMaskOf(ckLen)) == '0));

  a_r6_taken_rule: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ckScalar) |-> (taken == (resultMask == ckEff)));

  a_r2_scalar_result: assert property (@(posedge clk) disable iff (!rstN)
    (done && ckScalar) |-> (resultMask == '0 && !predWrEn));

  a_r4_scalar_addr: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ckVecA) |-> (rdAddrA == ckBaseA));

  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind vcmp_branch_eval vcmp_branch_eval_checker #(
  .MAXVL(MAXVL), .REGW(REGW), .VLW(VLW)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .vecLen     (vecLen),
  .predMask   (predMask),
  .predInvert (predInvert),
  .vecA       (vecA),
  .vecB       (vecB),
  .baseA      (baseA),
  .rdAddrA    (rdAddrA),
  .busy       (busy),
  .done       (done),
  .taken      (taken),
  .resultMask (resultMask),
  .predWrEn   (predWrEn),
  .predWrData (predWrData)
);

// File: tb/vcmp_branch_eval_test.sv
`timescale 1ns/1ps
module vcmp_branch_eval_test;

  localparam int XLEN = 32, MAXVL = 8, REGW = 5, VLW = 4;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [VLW-1:0] vecLen = '0;
  logic [MAXVL-1:0] predMask = '0;
  logic predInvert = 1'b0, vecA = 1'b0, vecB = 1'b0, hasTarget = 1'b0;
  logic [2:0] cmpOp = '0;
  logic [REGW-1:0] baseA = '0, baseB = '0, targetReg = '0;
  logic [REGW-1:0] rdAddrA, rdAddrB, predWrIdx;
  logic [XLEN-1:0] rdDataA, rdDataB;
  logic busy, done, taken, predWrEn;
  logic [MAXVL-1:0] resultMask, predWrData;
  logic [XLEN-1:0] regs [32];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  vcmp_branch_eval #(.XLEN(XLEN), .MAXVL(MAXVL), .REGW(REGW)) uut (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic cmpModel(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return a < b;
      4: return $signed(a) >= $signed(b);
      5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] pickVal();
    case ($urandom_range(0, 5))
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFF_FFFF;
      3: return 32'd2;
      4: return 32'h8000_0000;
      default: return 32'd1;
    endcase
  endfunction

  task automatic runCase(input logic va, input logic vb, input logic [4:0] ba,
                         input logic [4:0] bb, input logic [3:0] len,
                         input logic [7:0] pm, input logic inv, input logic [2:0] op,
                         input logic ht, input logic [4:0] tg, input bit intrude,
                         input string tag);
    bit scalar;
    int effLen, n;
    logic [7:0] eff, expMask;
    logic expTaken;
    scalar  = !va && !vb;
    effLen  = (len > 8) ? 8 : int'(len);
    eff     = '0;
    expMask = '0;
    for (int i = 0; i < 8; i++) begin
      eff[i] = (i < effLen) && (pm[i] ^ inv);
      if (eff[i] && cmpModel(op, regs[va ? ba + 5'(i) : ba], regs[vb ? bb + 5'(i) : bb]))
        expMask[i] = 1'b1;
    end
    if (scalar) begin
      expTaken = cmpModel(op, regs[ba], regs[bb]);
      expMask  = '0;
      n = 1;
    end else begin
      expTaken = (expMask == eff);
      n = (effLen == 0) ? 1 : effLen;
    end
    @(negedge clk);
    vecA = va; vecB = vb; baseA = ba; baseB = bb; vecLen = len; predMask = pm;
    predInvert = inv; cmpOp = op; hasTarget = ht; targetReg = tg; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", 32'(busy), 1);
    for (int k = 0; k < n; k++) begin
      check(rdAddrA == (va ? ba + 5'(k) : ba), "R4", "rdAddrA", 32'(rdAddrA), 32'(va ? ba + 5'(k) : ba));
      check(rdAddrB == (vb ? bb + 5'(k) : bb), "R4", "rdAddrB", 32'(rdAddrB), 32'(vb ? bb + 5'(k) : bb));
      check(done == 1'b0, "R7", "done early", 32'(done), 0);
      if (intrude && k == 0) begin
        start = 1'b1; vecA = !va; vecB = 1'b1; vecLen = 4'd3; predMask = ~pm;
        cmpOp = op + 3'd1; predInvert = !inv; hasTarget = !ht;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1, scalar ? "R2" : "R7", "done due", 32'(done), 1);
    check(taken == expTaken, tag, "taken", 32'(taken), 32'(expTaken));
    check(resultMask == expMask, scalar ? "R2" : "R5", "resultMask", 32'(resultMask), 32'(expMask));
    check(predWrEn == (!scalar && ht), "R8", "predWrEn", 32'(predWrEn), 32'(!scalar && ht));
    if (!scalar && ht) begin
      check(predWrIdx == tg, "R8", "predWrIdx", 32'(predWrIdx), 32'(tg));
      check(predWrData == expMask, "R8", "predWrData", 32'(predWrData), 32'(expMask));
    end
    @(negedge clk);
    check(done == 1'b0, "R7", "done pulse width", 32'(done), 0);
    check(busy == 1'b0, "R9", "busy after done", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 32; i++) regs[i] = pickVal();
    repeat (3) @(negedge clk);
    check(done == 0 && taken == 0 && resultMask == 0 && predWrEn == 0 && busy == 0,
          "R1", "reset outputs", {busy, predWrEn, taken, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: every op code through scalar compares on known pairs
    regs[1] = 32'd1; regs[2] = 32'hFFFF_FFFF; regs[3] = 32'd1;
    for (int op = 0; op < 8; op++) begin
      runCase(0, 0, 5'd1, 5'd2, 4'd5, 8'h00, 1'b1, 3'(op), 1'b1, 5'd9, 0, "R3");
      runCase(0, 0, 5'd2, 5'd1, 4'd0, 8'hFF, 1'b0, 3'(op), 1'b0, 5'd9, 0, "R3");
      runCase(0, 0, 5'd1, 5'd3, 4'd2, 8'h0F, 1'b0, 3'(op), 1'b0, 5'd9, 0, "R3");
    end

    // R6: zero vector length is taken, mask zero
    runCase(1, 1, 5'd4, 5'd8, 4'd0, 8'hFF, 1'b0, 3'd7, 1'b1, 5'd3, 0, "R6");
    // R6: invert of an empty predicate, all equal elements
    for (int i = 10; i < 20; i++) regs[i] = 32'd7;
    runCase(1, 0, 5'd10, 5'd12, 4'd6, 8'h00, 1'b1, 3'd0, 1'b1, 5'd1, 0, "R6");
    // R7: vector length above the maximum is clamped
    runCase(1, 1, 5'd10, 5'd11, 4'd15, 8'hFF, 1'b0, 3'd0, 1'b1, 5'd2, 0, "R7");
    // R3: code 6 never passes, so a full predicate is not taken
    runCase(1, 1, 5'd10, 5'd11, 4'd8, 8'hFF, 1'b0, 3'd6, 1'b0, 5'd2, 0, "R3");
    // R4: base wrap at the top of the register space
    runCase(1, 0, 5'd29, 5'd0, 4'd6, 8'hAA, 1'b0, 3'd5, 1'b1, 5'd7, 0, "R4");
    // R9: start during a walk is ignored
    runCase(1, 1, 5'd3, 5'd20, 4'd5, 8'h1D, 1'b0, 3'd2, 1'b1, 5'd5, 1, "R9");

    // Random mix
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < 32; i++) regs[i] = pickVal();
      runCase(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
              4'($urandom_range(0, 10)), 8'($urandom), 1'($urandom),
              3'($urandom_range(0, 7)), 1'($urandom), 5'($urandom),
              ($urandom_range(0, 7) == 0), "R6");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule